// File: doc/BRIEF.md
# Virtual-Wire Interrupt Receiver

This block sits at the front of an I/O interrupt controller. It accepts posted memory writes from a simple valid/ready write bus. It compares each write address against a base address supplied on an input port. A write that lands exactly 0x20 bytes above that base is treated as one pulse on an edge-triggered virtual interrupt wire. The low byte of its data word names the interrupt vector. The block turns that pulse into an upstream interrupt message, which is itself a memory write to a fixed message address.

Every other write passes through untouched as posted data. Posted data and interrupt messages share a single first-in first-out queue. Because of this, a message can never leave ahead of posted data that was accepted before the triggering write. When the queue is full, the write port stops accepting, so no event is lost. The offset of the assertion register is fixed relative to the base; software can move the base but not the offset.

Top module: `vwire_intr_rx`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0 and `wr_ready` is 1.
- R2: An accepted write with `wr_addr == base_addr + 0x20` produces one entry with `out_is_irq` = 1, `out_addr` = the `MSG_ADDR` parameter (default 0xFEE0_0000), and `out_data` = the write data bits [7:0] zero-extended to 32 bits.
- R3: Bits [31:8] of the data of an assertion write have no effect; the emitted vector depends only on bits [7:0].
- R4: An accepted write to any other address produces one entry with `out_is_irq` = 0, and with `out_addr` and `out_data` equal to the write's address and data.
- R5: Entries leave in the order their writes were accepted, so a message never precedes posted data accepted earlier.
- R6: Once `DEPTH` entries (default 4) are held, `wr_ready` is 0 and no write is taken until an entry leaves; no accepted entry is lost.
- R7: Each assertion write is a separate event: two identical assertion writes give two messages, and no level or deassert state remains.
- R8: The decode follows `base_addr`: after the base changes, the old base plus 0x20 is posted data, and the new base plus 0x20 is decoded. Base plus 0x24 is never decoded.
- R9: While `out_valid` is 1 and `out_ready` is 0, the output entry stays valid and unchanged.
- R10: With an empty queue, `out_valid` rises one cycle after the clock edge that accepts a write; it is 1 exactly while the queue holds at least one entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_addr | input | ADDR_W | Base address of the controller's register window |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write accepted at this edge when also valid |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| out_valid | output | 1 | Outbound entry present |
| out_ready | input | 1 | Downstream takes the entry |
| out_is_irq | output | 1 | 1: interrupt message, 0: posted data |
| out_addr | output | ADDR_W | Outbound write address |
| out_data | output | DATA_W | Outbound write data |

## Verification
A write is accepted at the rising edge where `wr_valid` and `wr_ready` are both high. Its entry is at the head one cycle later if the queue was empty. `wr_ready` drops after the same edge that fills the last slot. The next entry appears one cycle after the edge that pops the head. Every check samples at the falling edge that follows the relevant rising edge, when all registered state has settled. Stimulus changes only at falling edges, so the bench never races a design register.

// File: rtl/vwire_pkg.sv
package vwire_pkg;

  parameter int ADDR_W  = 32;
  parameter int DATA_W  = 32;
  parameter int VEC_W   = 8;
  // Byte offset of the assertion register; fixed relative to the base.
  parameter int PIN_OFS = 32'h20;

  typedef enum logic {
    ENT_POSTED = 1'b0,
    ENT_IRQMSG = 1'b1
  } ent_kind_e;

  typedef struct packed {
    ent_kind_e         kind;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } vwire_entry_t;

  localparam int ENTRY_W = $bits(vwire_entry_t);

endpackage

// File: rtl/vwire_decode.sv
module vwire_decode
  import vwire_pkg::*;
(
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              pin_hit
);

  logic [ADDR_W-1:0] pin_addr;

  always_comb begin
    pin_addr = base_addr + ADDR_W'(PIN_OFS);
    pin_hit  = (wr_addr == pin_addr);
  end

endmodule

// File: rtl/vwire_msg_build.sv
module vwire_msg_build
  import vwire_pkg::*;
#(
  parameter logic [ADDR_W-1:0] MSG_ADDR = 32'hFEE0_0000
) (
  input  logic              pin_hit,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output vwire_entry_t      entry
);

  logic [VEC_W-1:0] vector;

  always_comb begin
    vector = wr_data[VEC_W-1:0];
    if (pin_hit) begin
      entry.kind = ENT_IRQMSG;
      entry.addr = MSG_ADDR;
      entry.data = DATA_W'(vector);
    end else begin
      entry.kind = ENT_POSTED;
      entry.addr = wr_addr;
      entry.data = wr_data;
    end
  end

endmodule

// File: rtl/vwire_fifo.sv
module vwire_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 65
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic             full,
  output logic             nonempty,
  output logic [WIDTH-1:0] head
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
  endfunction

  // Storage has no reset so it can map to RAM.
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  always_comb begin
    full     = (count == FULL_CNT);
    nonempty = (count != '0);
    head     = mem[rd_ptr];
  end

endmodule

// File: rtl/vwire_intr_rx.sv
module vwire_intr_rx
  import vwire_pkg::*;
#(
  parameter int                DEPTH    = 4,
  parameter logic [ADDR_W-1:0] MSG_ADDR = 32'hFEE0_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_is_irq,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data
);

  logic               pin_hit;
  vwire_entry_t       in_entry;
  vwire_entry_t       head_entry;
  logic [ENTRY_W-1:0] head_bits;
  logic               q_full, q_nonempty;
  logic               do_push, do_pop;

  vwire_decode u_decode (
    .base_addr (base_addr),
    .wr_addr   (wr_addr),
    .pin_hit   (pin_hit)
  );

  vwire_msg_build #(.MSG_ADDR(MSG_ADDR)) u_build (
    .pin_hit (pin_hit),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .entry   (in_entry)
  );

  always_comb begin
    wr_ready = !q_full;
    do_push  = wr_valid && !q_full;
    do_pop   = out_ready && q_nonempty;
  end

  vwire_fifo #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_queue (
    .clk       (clk),
    .rst       (rst),
    .push      (do_push),
    .push_data (in_entry),
    .pop       (do_pop),
    .full      (q_full),
    .nonempty  (q_nonempty),
    .head      (head_bits)
  );

  always_comb begin
    head_entry = vwire_entry_t'(head_bits);
    out_valid  = q_nonempty;
    out_is_irq = (head_entry.kind == ENT_IRQMSG);
    out_addr   = head_entry.addr;
    out_data   = head_entry.data;
  end

endmodule

// File: rtl/vwire_intr_rx_chk.sv
module vwire_intr_rx_chk
  import vwire_pkg::*;
#(
  parameter int                DEPTH    = 4,
  parameter logic [ADDR_W-1:0] MSG_ADDR = 32'hFEE0_0000
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_is_irq,
  input logic [ADDR_W-1:0] out_addr,
  input logic [DATA_W-1:0] out_data
);

  int occ;

  always_ff @(posedge clk) begin
    if (rst) occ <= 0;
    else     occ <= occ + int'(wr_valid && wr_ready) - int'(out_valid && out_ready);
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && wr_ready));

  p_msg_format_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_is_irq) |-> (out_addr == MSG_ADDR && out_data[DATA_W-1:VEC_W] == '0));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    wr_ready == (occ < DEPTH));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_is_irq) &&
                                   $stable(out_addr) && $stable(out_data)));

  p_valid_tracks_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid == (occ != 0));

endmodule

bind vwire_intr_rx vwire_intr_rx_chk #(.DEPTH(DEPTH), .MSG_ADDR(MSG_ADDR)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_is_irq (out_is_irq),
  .out_addr   (out_addr),
  .out_data   (out_data)
);

// File: tb/test_vwire_intr_rx.sv
module test_vwire_intr_rx;

  localparam int          CLK_NS = 10;
  localparam int          DEPTH  = 4;
  localparam logic [31:0] MSG    = 32'hFEE0_0000;
  localparam logic [31:0] BASE0  = 32'hFEC0_0000;
  localparam logic [31:0] BASE1  = 32'hFEC1_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] base_addr = BASE0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [31:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        out_is_irq;
  logic [31:0] out_addr;
  logic [31:0] out_data;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  vwire_intr_rx #(.DEPTH(DEPTH), .MSG_ADDR(MSG)) i_vwire_intr_rx (
    .clk(clk), .rst(rst), .base_addr(base_addr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_is_irq(out_is_irq),
    .out_addr(out_addr), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at a falling edge.
  task automatic send(input logic [31:0] a, input logic [31:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic take(input bit irq, input logic [31:0] a, input logic [31:0] d, input string req);
    chk(out_valid == 1'b1, req, 64'(out_valid), 64'd1);
    chk(out_is_irq == irq && out_addr == a && out_data == d, req,
        {out_is_irq, out_addr[30:0], out_data}, {irq, a[30:0], d});
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic expect_empty(input string req);
    chk(out_valid == 1'b0, req, 64'(out_valid), 64'd0);
  endtask

  task automatic t_reset;
    chk(out_valid == 1'b0 && wr_ready == 1'b1, "R1 reset state",
        {out_valid, wr_ready}, 64'b01);
  endtask

  task automatic t_single_assert;
    send(BASE0 + 32'h20, 32'hABCD_1241);
    chk(out_valid == 1'b1, "R10 one-cycle latency", 64'(out_valid), 64'd1);
    take(1'b1, MSG, 32'h41, "R2 R3 message from assertion write");
    expect_empty("R7 single event only");
  endtask

  task automatic t_posted;
    send(BASE0 + 32'h100, 32'h1234_5678);
    take(1'b0, BASE0 + 32'h100, 32'h1234_5678, "R4 posted passthrough");
    send(32'h0000_1000, 32'hFFFF_FF00);
    take(1'b0, 32'h0000_1000, 32'hFFFF_FF00, "R4 posted outside window");
  endtask

  task automatic t_order;
    send(BASE0 + 32'h40, 32'hA1);
    send(BASE0 + 32'h44, 32'hB2);
    send(BASE0 + 32'h20, 32'h5555_5533);
    send(BASE0 + 32'h48, 32'hC3);
    take(1'b0, BASE0 + 32'h40, 32'hA1, "R5 order first posted");
    take(1'b0, BASE0 + 32'h44, 32'hB2, "R5 order second posted");
    take(1'b1, MSG, 32'h33, "R5 message after posted data");
    take(1'b0, BASE0 + 32'h48, 32'hC3, "R5 order trailing posted");
    expect_empty("R5 drained");
  endtask

  task automatic t_full;
    for (int i = 0; i < DEPTH; i++) send(BASE0 + 32'h200 + 32'(i * 4), 32'(i + 16));
    chk(wr_ready == 1'b0, "R6 ready low when full", 64'(wr_ready), 64'd0);
    wr_valid = 1'b1; wr_addr = BASE0 + 32'h20; wr_data = 32'h99;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(wr_ready == 1'b0, "R6 stays blocked", 64'(wr_ready), 64'd0);
    end
    wr_valid = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      take(1'b0, BASE0 + 32'h200 + 32'(i * 4), 32'(i + 16), "R6 no loss when full");
    expect_empty("R6 blocked write not taken");
    chk(wr_ready == 1'b1, "R6 ready restored", 64'(wr_ready), 64'd1);
  endtask

  task automatic t_edge;
    send(BASE0 + 32'h20, 32'h0000_0077);
    send(BASE0 + 32'h20, 32'h0000_0077);
    take(1'b1, MSG, 32'h77, "R7 first event");
    take(1'b1, MSG, 32'h77, "R7 second event");
    expect_empty("R7 no lingering level");
  endtask

  task automatic t_base_move;
    base_addr = BASE1;
    send(BASE0 + 32'h20, 32'h0000_0011);
    send(BASE1 + 32'h20, 32'hFFFF_FF22);
    send(BASE1 + 32'h24, 32'h0000_0033);
    take(1'b0, BASE0 + 32'h20, 32'h11, "R8 old base is posted");
    take(1'b1, MSG, 32'h22, "R8 R3 new base decoded");
    take(1'b0, BASE1 + 32'h24, 32'h33, "R8 neighbour offset posted");
    base_addr = BASE0;
  endtask

  task automatic t_hold;
    send(BASE0 + 32'h20, 32'h0000_00E5);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(out_valid && out_is_irq && out_addr == MSG && out_data == 32'hE5,
          "R9 held while stalled", {out_valid, out_is_irq, out_data}, {2'b11, 32'hE5});
    end
    take(1'b1, MSG, 32'hE5, "R9 released");
    expect_empty("R9 drained");
  endtask

  initial begin
    #(CLK_NS * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_single_assert();
    t_posted();
    t_order();
    t_full();
    t_edge();
    t_base_move();
    t_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule